// File: doc/BRIEF.md
# Primary-Rate TDM Frame Timing Generator

This block produces the timing for a 2048 kbit/s primary-rate time-division multiplex. It is paced by a single bit-clock enable. Every enabled cycle sends one line bit. The block keeps the current position in three counters:

- the channel index (0 to 31);
- the bit-plane index (0 to 7);
- the frame index within a 16-frame multiframe.

From this position it derives the frame-start strobe, the multiframe-start strobe and a flag that marks the two control channels.

The block also serializes 32 parallel 8-bit channel words onto one line. It sends them plane by plane: bit 0 of channels 0 through 31, then bit 1 of channels 0 through 31, and so on up to bit 7. That gives 256 bits per frame and 4096 bits per multiframe. The channel words and a 4-bit recognition field are copied into a shadow store when a frame starts, so a change on the inputs during a frame does not reach the line until the next frame. In the first frame of each multiframe, the block replaces the word of channel 16 with the multiframe recognition pattern, which has four leading zeros.

Top module: `tdm_frame_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the position becomes frame 0, plane 0, channel 0, and the shadow store is cleared.
- R2: Each cycle with `bit_en` high advances `chan_idx` by one at the following edge. A cycle with `bit_en` low leaves `chan_idx`, `plane_idx` and `frame_idx` unchanged.
- R3: After channel 31, `chan_idx` returns to 0 and `plane_idx` advances. After plane 7 with channel 31, `plane_idx` returns to 0 and `frame_idx` advances. `frame_idx` counts 0 to 15 and then wraps to 0.
- R4: `ser_out` carries bit `plane_idx` of the word of channel `chan_idx` as held in the shadow store. The word of channel c occupies `chan_words[8c+7:8c]`, and word bit 0 is sent first.
- R5: `ctrl_chan` is high exactly when `chan_idx` is 0 or 16, whether or not `bit_en` is high.
- R6: `frame_start` is high exactly in the cycles where `bit_en` is high and the position is plane 0, channel 0.
- R7: `multiframe_start` is high exactly when `frame_start` is high and `frame_idx` is 0.
- R8: In frame 0, channel 16 sends 0 on planes 0 to 3 and sends `mf_xy[k]` on plane 4+k. In frames 1 to 15, channel 16 sends its own word.
- R9: `chan_words` and `mf_xy` are copied into the shadow store at the edge ending a `frame_start` cycle. Changes to them at any other time do not affect `ser_out` until the next frame start.
- R10: Whenever the position is plane 0, channel 0, `ser_out` is taken directly from `chan_words[0]`. This lets the first bit of a frame use the new words in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; one line bit per high cycle |
| chan_words | input | 256 | 32 channel words, channel c at bits 8c+7:8c |
| mf_xy | input | 4 | Recognition field placed on planes 4..7 of channel 16 in frame 0 |
| ser_out | output | 1 | Serial line bit for the current position |
| frame_start | output | 1 | First bit of a frame being sent this cycle |
| multiframe_start | output | 1 | First bit of a multiframe being sent this cycle |
| chan_idx | output | 5 | Current channel index |
| plane_idx | output | 3 | Current bit-plane index |
| frame_idx | output | 4 | Current frame within the multiframe |
| ctrl_chan | output | 1 | Current channel is a control channel (0 or 16) |

## Verification
Three things happen in the same cycle when a multiframe begins: the frame-start strobe, the multiframe strobe, and the shadow capture that loads the recognition pattern into channel 16. In that same cycle, the first line bit is taken from the live input. The bench provokes this by pausing the enable at random while it changes the channel words and recognition field on every cycle, so the wrap to frame 0 sometimes arrives after idle cycles and sometimes without them. A behavioural model in the bench decides each cycle which source feeds the line, whether the live word, the shadowed word or the inserted pattern, and every output is compared against it.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;
    localparam int unsigned NUM_CH  = 32;
    localparam int unsigned WORD_W  = 8;
    localparam int unsigned FRAMES  = 16;
    localparam int unsigned XY_W    = 4;
    localparam int unsigned CTRL_A  = 0;
    localparam int unsigned CTRL_B  = 16;
    localparam int unsigned CH_W    = $clog2(NUM_CH);
    localparam int unsigned PL_W    = $clog2(WORD_W);
    localparam int unsigned FR_W    = $clog2(FRAMES);
    localparam int unsigned BUS_W   = NUM_CH * WORD_W;

    typedef struct packed {
        logic [FR_W-1:0] frame;
        logic [PL_W-1:0] plane;
        logic [CH_W-1:0] chan;
    } tdm_pos_t;

    function automatic logic is_ctrl(input logic [CH_W-1:0] c);
        return (c == CH_W'(CTRL_A)) || (c == CH_W'(CTRL_B));
    endfunction

    // recognition word: low planes zero, high planes carry the field
    function automatic logic [WORD_W-1:0] mf_word(input logic [XY_W-1:0] xy);
        return {xy, {(WORD_W-XY_W){1'b0}}};
    endfunction
endpackage

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter
    import tdm_frame_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    output tdm_pos_t pos
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (adv) begin
            if (pos.chan == CH_W'(NUM_CH-1)) begin
                pos.chan <= '0;
                if (pos.plane == PL_W'(WORD_W-1)) begin
                    pos.plane <= '0;
                    pos.frame <= (pos.frame == FR_W'(FRAMES-1)) ? '0 : pos.frame + 1'b1;
                end else begin
                    pos.plane <= pos.plane + 1'b1;
                end
            end else begin
                pos.chan <= pos.chan + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_shadow.sv
module tdm_shadow
    import tdm_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             mf_first,
    input  logic [BUS_W-1:0] live_words,
    input  logic [XY_W-1:0]  xy,
    output logic [BUS_W-1:0] held_words
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [WORD_W-1:0] next_word;
        if (c == CTRL_B) begin : g_sig
            assign next_word = mf_first ? mf_word(xy) : live_words[c*WORD_W +: WORD_W];
        end else begin : g_plain
            assign next_word = live_words[c*WORD_W +: WORD_W];
        end
        always_ff @(posedge clk) begin
            if (rst)
                held_words[c*WORD_W +: WORD_W] <= '0;
            else if (capture)
                held_words[c*WORD_W +: WORD_W] <= next_word;
        end
    end
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
    import tdm_frame_pkg::*;
(
    input  tdm_pos_t         pos,
    input  logic             at_first,
    input  logic [BUS_W-1:0] live_words,
    input  logic [BUS_W-1:0] held_words,
    output logic             bit_out
);
    logic [CH_W+PL_W-1:0] sel;
    always_comb begin
        sel = {pos.chan, PL_W'(0)} | {{CH_W{1'b0}}, pos.plane};
        if (at_first)
            bit_out = live_words[0];
        else
            bit_out = held_words[sel];
    end
endmodule

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen
    import tdm_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic [BUS_W-1:0] chan_words,
    input  logic [XY_W-1:0]  mf_xy,
    output logic             ser_out,
    output logic             frame_start,
    output logic             multiframe_start,
    output logic [CH_W-1:0]  chan_idx,
    output logic [PL_W-1:0]  plane_idx,
    output logic [FR_W-1:0]  frame_idx,
    output logic             ctrl_chan
);
    tdm_pos_t         pos;
    logic             at_first;
    logic [BUS_W-1:0] held_words;

    tdm_pos_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .adv (bit_en),
        .pos (pos)
    );

    assign at_first         = (pos.chan == '0) && (pos.plane == '0);
    assign frame_start      = bit_en && at_first;
    assign multiframe_start = frame_start && (pos.frame == '0);

    tdm_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .capture    (frame_start),
        .mf_first   (pos.frame == '0),
        .live_words (chan_words),
        .xy         (mf_xy),
        .held_words (held_words)
    );

    tdm_serializer u_ser (
        .pos        (pos),
        .at_first   (at_first),
        .live_words (chan_words),
        .held_words (held_words),
        .bit_out    (ser_out)
    );

    assign chan_idx  = pos.chan;
    assign plane_idx = pos.plane;
    assign frame_idx = pos.frame;
    assign ctrl_chan = is_ctrl(pos.chan);
endmodule

// File: rtl/tdm_frame_gen_chk.sv
module tdm_frame_gen_chk
    import tdm_frame_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            bit_en,
    input logic            ser_out,
    input logic            frame_start,
    input logic            multiframe_start,
    input logic [CH_W-1:0] chan_idx,
    input logic [PL_W-1:0] plane_idx,
    input logic [FR_W-1:0] frame_idx
);
    AST_CHAN_STEP: assert property (@(posedge clk) disable iff (rst)
        bit_en && (chan_idx != CH_W'(NUM_CH-1)) |=> chan_idx == $past(chan_idx) + 1'b1); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(chan_idx) && $stable(plane_idx) && $stable(frame_idx)); // R2
    AST_CHAN_WRAP: assert property (@(posedge clk) disable iff (rst)
        bit_en && (chan_idx == CH_W'(NUM_CH-1)) |=> chan_idx == '0 && plane_idx != $past(plane_idx)); // R3
    AST_FS_POSITION: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> bit_en && chan_idx == '0 && plane_idx == '0); // R6
    AST_MF_IN_FS: assert property (@(posedge clk) disable iff (rst)
        multiframe_start |-> frame_start && frame_idx == '0); // R7
    AST_PATTERN_ZERO: assert property (@(posedge clk) disable iff (rst)
        frame_idx == '0 && chan_idx == CH_W'(CTRL_B) && plane_idx < PL_W'(WORD_W-XY_W) |-> !ser_out); // R8
endmodule

bind tdm_frame_gen tdm_frame_gen_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .bit_en           (bit_en),
    .ser_out          (ser_out),
    .frame_start      (frame_start),
    .multiframe_start (multiframe_start),
    .chan_idx         (chan_idx),
    .plane_idx        (plane_idx),
    .frame_idx        (frame_idx)
);

// File: tb/tdm_frame_gen_test.sv
`timescale 1ns/1ps
module tdm_frame_gen_test;
    logic         clk = 0;
    logic         rst = 1;
    logic         bit_en = 0;
    logic [255:0] chan_words = '0;
    logic [3:0]   mf_xy = '0;
    logic         ser_out, frame_start, multiframe_start, ctrl_chan;
    logic [4:0]   chan_idx;
    logic [2:0]   plane_idx;
    logic [3:0]   frame_idx;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // behavioural model state
    int           m_ch, m_pl, m_fr;
    logic [255:0] m_words;
    logic [3:0]   m_xy;

    always #2.5 clk = ~clk;

    tdm_frame_gen uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .chan_words(chan_words), .mf_xy(mf_xy),
        .ser_out(ser_out), .frame_start(frame_start), .multiframe_start(multiframe_start),
        .chan_idx(chan_idx), .plane_idx(plane_idx), .frame_idx(frame_idx), .ctrl_chan(ctrl_chan)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        int  exp_bit;
        bit  first;
        first = (m_ch == 0) && (m_pl == 0);
        check("R2/R3", "chan_idx", int'(chan_idx), m_ch);
        check("R3", "plane_idx", int'(plane_idx), m_pl);
        check("R3", "frame_idx", int'(frame_idx), m_fr);
        check("R5", "ctrl_chan", int'(ctrl_chan), (m_ch == 0 || m_ch == 16) ? 1 : 0);
        check("R6", "frame_start", int'(frame_start), (bit_en && first) ? 1 : 0);
        check("R7", "multiframe_start", int'(multiframe_start), (bit_en && first && m_fr == 0) ? 1 : 0);
        if (first)
            exp_bit = int'(chan_words[0]);                       // R10
        else if (m_fr == 0 && m_ch == 16)
            exp_bit = (m_pl < 4) ? 0 : int'(m_xy[m_pl-4]);       // R8
        else
            exp_bit = int'(m_words[m_ch*8 + m_pl]);              // R4, R9
        check("R4/R8/R9/R10", "ser_out", int'(ser_out), exp_bit);
    endtask

    task automatic model_step();
        if (!bit_en) return;
        if (m_ch == 0 && m_pl == 0) begin
            m_words = chan_words;
            m_xy    = mf_xy;
        end
        if (m_ch == 31) begin
            m_ch = 0;
            if (m_pl == 7) begin
                m_pl = 0;
                m_fr = (m_fr == 15) ? 0 : m_fr + 1;
            end else m_pl++;
        end else m_ch++;
    endtask

    initial begin
        m_ch = 0; m_pl = 0; m_fr = 0; m_words = '0; m_xy = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: position after reset
        check("R1", "reset chan", int'(chan_idx), 0);
        check("R1", "reset plane", int'(plane_idx), 0);
        check("R1", "reset frame", int'(frame_idx), 0);
        for (int cyc = 0; cyc < 12000; cyc++) begin
            @(negedge clk);
            bit_en     = ($urandom_range(0, 3) != 0);
            chan_words = {$urandom, $urandom, $urandom, $urandom,
                          $urandom, $urandom, $urandom, $urandom};
            mf_xy      = 4'($urandom);
            #1;
            compare_all();
            model_step();
        end
        // R1: reset in mid-frame
        @(negedge clk);
        rst = 1; bit_en = 1;
        @(negedge clk);
        rst = 0; bit_en = 0;
        m_ch = 0; m_pl = 0; m_fr = 0; m_words = '0; m_xy = '0;
        #1;
        check("R1", "mid reset chan", int'(chan_idx), 0);
        compare_all();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule